// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small bank of control and status words on a single-cycle 32-bit register bus. Software reaches it with an address, a read strobe, a write strobe and write data. Read data and an error flag come back one clock later. The bank holds a fixed identification word, an LED word that also drives output pins, and two general configuration words. It also holds two flag words, one cleared by reset and one that keeps its contents across reset. Each flag word has its own set address and its own clear address. A free-running tick count advances at a fixed fraction of the bus clock.

The reset control word is protected by a key. It accepts a write only while the lock word holds the key value. An accepted write whose request bit is set produces a one-cycle reset request pulse. The position of that request bit comes from a board-variant field inside the identification word, so one description of the block serves several boards. On variants without a reset control word, that address reads zero and ignores writes.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, the LED word, lock word, both configuration words, the volatile flags and the reset control word all read 0, and `led_o` is 0.
- R2: Lock word at offset 0x20. A write of exactly 0x0000A05F stores 0xA05F. Any other write stores `wdata & 0x7FFF`, so bit 15 reads 0. Reads return the value zero-extended.
- R3: A write to the reset control word (offset 0x40) is accepted only when the lock word currently equals 0xA05F. Otherwise the stored value does not change.
- R4: The board variant is bits 27:16 of the identification word. For variant 0x100 the request bit is bit 8. For variants 0x178 and 0x182 it is bit 2. An accepted write with the request bit set drives `rst_req_o` high for exactly the one cycle after the write.
- R5: For any other variant, offset 0x40 reads 0, ignores writes and never raises `rst_req_o`.
- R6: A write to 0x30 ORs the data into the volatile flags. A write to 0x34 clears the flag bits that are 1 in the data. A read of 0x30 returns the flags, and a read of 0x34 returns 0.
- R7: Offsets 0x38 (set) and 0x3C (clear) act the same way on the non-volatile flags, which read at 0x38. Their contents survive `rst_n`.
- R8: Fixed reads: 0x00 returns the `SYS_ID` parameter, 0x44 returns 1, 0x84 returns the `PROC_ID` parameter, and 0x88 returns 0xFF000000.
- R9: Offset 0x5C returns a count that advances by at most 1 per clock. Over D cycles it advances by floor or ceil of D·TICK_HZ/CLK_HZ.
- R10: An access (read or write) to a misaligned offset, or to a word index outside 0x00–0x74, 0x80–0x9C and 0xC0–0xD0, raises `bus_err` for one cycle and reads 0. Mapped offsets never raise it. Every mapped offset not listed in R2–R9 or R11 reads 0.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. The LED word (0x08) and the configuration words (0x28, 0x2C) read back the last value written, and `led_o` follows the LED word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | Unmapped-access flag, one cycle after the access |
| led_o | output | 32 | Current LED word |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds three copies of the bank that share one bus: variant 0x178 (request bit 2), variant 0x100 (request bit 8) and variant 0x140 (reserved reset control). A single key-guarded write therefore exercises both request-bit positions and the read-as-zero case side by side. The address width is left at 12 with a 50 MHz clock and a 24 MHz tick. This sweeps every byte offset in the lowest 256 bytes against an arithmetic model of the map and measures tick growth over several spans whose ratio is not an integer.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
   localparam int DW = 32;
   localparam logic [15:0] LOCK_KEY = 16'hA05F;

   localparam int unsigned OFS_ID       = 32'h00;
   localparam int unsigned OFS_LED      = 32'h08;
   localparam int unsigned OFS_LOCK     = 32'h20;
   localparam int unsigned OFS_CFG0     = 32'h28;
   localparam int unsigned OFS_FLAG_SET = 32'h30;
   localparam int unsigned OFS_RSTCTL   = 32'h40;
   localparam int unsigned OFS_ONE      = 32'h44;
   localparam int unsigned OFS_TICK     = 32'h5C;
   localparam int unsigned OFS_PROC0    = 32'h84;
   localparam int unsigned OFS_PROC1    = 32'h88;

   localparam int CFG_N  = 2;
   localparam int FLAG_N = 2;

   // Position of the reset request bit for a board variant; -1 means the
   // reset control word is reserved on that variant.
   function automatic int req_bit_for(input logic [11:0] variant);
      case (variant)
         12'h100:          return 8;
         12'h178, 12'h182: return 2;
         default:          return -1;
      endcase
   endfunction
endpackage

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
   parameter int W           = 32,
   parameter bit KEEP_ON_RST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic [W-1:0] q_nxt;

   always_comb begin
      q_nxt = q;
      if (set_en)      q_nxt = q | din;
      else if (clr_en) q_nxt = q & ~din;
   end

   if (KEEP_ON_RST) begin : g_keep
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) q <= q_nxt;
   end else begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= q_nxt;
      end
   end
endmodule

// File: rtl/sysreg_lockrst.sv
module sysreg_lockrst
   import sysreg_pkg::*;
#(
   parameter int REQ_BIT = -1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock_we,
   input  logic          ctl_we,
   input  logic [DW-1:0] wdata,
   output logic [15:0]   lock_q,
   output logic [DW-1:0] level_q,
   output logic          req_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= '0;
      else if (lock_we) lock_q <= (wdata == DW'(LOCK_KEY)) ? LOCK_KEY
                                                           : {1'b0, wdata[14:0]};
   end

   if (REQ_BIT >= 0) begin : g_ctl
      logic open_q;
      assign open_q = (lock_q == LOCK_KEY);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= '0;
            req_o   <= 1'b0;
         end else begin
            req_o <= ctl_we && open_q && wdata[REQ_BIT];
            if (ctl_we && open_q) level_q <= wdata;
         end
      end
   end else begin : g_reserved
      logic unused_ctl;
      assign unused_ctl = ctl_we;
      assign level_q    = '0;
      assign req_o      = 1'b0;
   end
endmodule

// File: rtl/sysreg_tick.sv
module sysreg_tick #(
   parameter int CLK_HZ  = 50_000_000,
   parameter int TICK_HZ = 24_000_000,
   parameter int TICK_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TICK_W-1:0] cnt_q
);
   if (TICK_HZ == CLK_HZ) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_q + TICK_W'(1);
      end
   end else begin : g_frac
      localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
      logic [ACC_W-1:0] acc_q, acc_sum;
      logic             wrap;
      assign acc_sum = acc_q + ACC_W'(TICK_HZ);
      assign wrap    = (acc_sum >= ACC_W'(CLK_HZ));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= wrap ? (acc_sum - ACC_W'(CLK_HZ)) : acc_sum;
            cnt_q <= cnt_q + TICK_W'(wrap);
         end
      end
   end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
   import sysreg_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter logic [31:0] SYS_ID  = 32'h0178_0000,
   parameter logic [31:0] PROC_ID = 32'h0C00_0000,
   parameter int          CLK_HZ  = 50_000_000,
   parameter int          TICK_HZ = 24_000_000,
   parameter int          TICK_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              bus_err,
   output logic [DW-1:0]     led_o,
   output logic              rst_req_o
);
   localparam logic [11:0] VARIANT = SYS_ID[27:16];
   localparam int          REQ_BIT = req_bit_for(VARIANT);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("sysreg_bank: ADDR_W must lie in 8..32");
   end
   if (TICK_HZ <= 0 || TICK_HZ > CLK_HZ) begin : g_bad_tick
      $error("sysreg_bank: TICK_HZ must lie in 1..CLK_HZ");
   end
   if (TICK_W < 1 || TICK_W > DW) begin : g_bad_tickw
      $error("sysreg_bank: TICK_W must lie in 1..32");
   end

   logic [31:0]       a32;
   logic [31:0]       widx;
   logic              mapped;
   logic [DW-1:0]     led_q;
   logic [DW-1:0]     cfg_q  [CFG_N];
   logic [DW-1:0]     flag_q [FLAG_N];
   logic [15:0]       lock_q;
   logic [DW-1:0]     level_q;
   logic [TICK_W-1:0] tick_q;
   logic [DW-1:0]     rd_mux;

   assign a32    = 32'(bus_addr);
   assign widx   = a32 >> 2;
   assign mapped = (a32[1:0] == 2'b00) &&
                   ((widx <= 32'h1D) ||
                    (widx >= 32'h20 && widx <= 32'h27) ||
                    (widx >= 32'h30 && widx <= 32'h34));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          led_q <= '0;
      else if (bus_wr && a32 == OFS_LED)   led_q <= bus_wdata;
   end
   assign led_o = led_q;

   for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      cfg_q[i] <= '0;
         else if (bus_wr && a32 == 32'(OFS_CFG0 + 4*i))   cfg_q[i] <= bus_wdata;
      end
   end

   // Index 0: volatile flags; index 1: flags kept across reset.
   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      sysreg_setclr #(.W(DW), .KEEP_ON_RST(i == 1)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (bus_wr && a32 == 32'(OFS_FLAG_SET + 8*i)),
         .clr_en (bus_wr && a32 == 32'(OFS_FLAG_SET + 8*i + 4)),
         .din    (bus_wdata),
         .q      (flag_q[i])
      );
   end

   sysreg_lockrst #(.REQ_BIT(REQ_BIT)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_we (bus_wr && a32 == OFS_LOCK),
      .ctl_we  (bus_wr && a32 == OFS_RSTCTL),
      .wdata   (bus_wdata),
      .lock_q  (lock_q),
      .level_q (level_q),
      .req_o   (rst_req_o)
   );

   sysreg_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .TICK_W(TICK_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_q (tick_q)
   );

   always_comb begin
      case (a32)
         OFS_ID:           rd_mux = SYS_ID;
         OFS_LED:          rd_mux = led_q;
         OFS_LOCK:         rd_mux = {16'h0000, lock_q};
         OFS_CFG0:         rd_mux = cfg_q[0];
         OFS_CFG0 + 4:     rd_mux = cfg_q[1];
         OFS_FLAG_SET:     rd_mux = flag_q[0];
         OFS_FLAG_SET + 8: rd_mux = flag_q[1];
         OFS_RSTCTL:       rd_mux = level_q;
         OFS_ONE:          rd_mux = 32'd1;
         OFS_TICK:         rd_mux = DW'(tick_q);
         OFS_PROC0:        rd_mux = PROC_ID;
         OFS_PROC1:        rd_mux = 32'hFF00_0000;
         default:          rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= bus_rd ? rd_mux : '0;
         bus_err   <= (bus_rd || bus_wr) && !mapped;
      end
   end
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
   import sysreg_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int REQ_BIT = -1,
   parameter int TICK_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DW-1:0]     bus_wdata,
   input logic              bus_err,
   input logic              rst_req_o,
   input logic [15:0]       lock_q,
   input logic [DW-1:0]     level_q,
   input logic [TICK_W-1:0] tick_q
);
   localparam int REQ_IDX = (REQ_BIT < 0) ? 0 : REQ_BIT;
   localparam bit RC_EN   = (REQ_BIT >= 0);

   logic ctl_acc;
   logic unused_chk;
   assign ctl_acc    = bus_wr && (32'(bus_addr) == OFS_RSTCTL) && (lock_q == LOCK_KEY);
   assign unused_chk = ^bus_wdata;

   p_lock_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[15] |-> (lock_q == LOCK_KEY));

   p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_acc |=> $stable(level_q));

   p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (RC_EN && $past(ctl_acc && bus_wdata[REQ_IDX])));

   p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd || bus_wr));

   p_tick_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((tick_q == $past(tick_q)) || (tick_q == $past(tick_q) + TICK_W'(1))));
endmodule

bind sysreg_bank sysreg_bank_chk #(
   .ADDR_W  (ADDR_W),
   .REQ_BIT (REQ_BIT),
   .TICK_W  (TICK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_err   (bus_err),
   .rst_req_o (rst_req_o),
   .lock_q    (lock_q),
   .level_q   (level_q),
   .tick_q    (tick_q)
);

// File: tb/sysreg_bank_tb.sv
module sysreg_bank_tb;
   localparam logic [31:0] ID_A = 32'h0178_0000;
   localparam logic [31:0] ID_B = 32'h0100_0000;
   localparam logic [31:0] ID_C = 32'h0140_0000;
   localparam logic [31:0] PID  = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdat_a, rdat_b, rdat_c, led_a, led_b, led_c;
   logic        err_a, err_b, err_c, req_a, req_b, req_c;

   int nvec = 0, nerr = 0;
   int cyc = 0;
   logic [31:0] ra, rb, rc;
   logic        ea;
   int          rcyc;

   // bench model of the main copy
   logic [31:0] m_led, m_cfg0, m_cfg1, m_flags, m_nv, m_level;
   logic [15:0] m_lock;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sysreg_bank #(.SYS_ID(ID_A), .PROC_ID(PID)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdat_a), .bus_err(err_a), .led_o(led_a),
      .rst_req_o(req_a));
   sysreg_bank #(.SYS_ID(ID_B), .PROC_ID(PID)) u_old (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdat_b), .bus_err(err_b), .led_o(led_b),
      .rst_req_o(req_b));
   sysreg_bank #(.SYS_ID(ID_C), .PROC_ID(PID)) u_rsv (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdat_c), .bus_err(err_c), .led_o(led_c),
      .rst_req_o(req_c));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      ea = err_a;
   endtask

   task automatic bus_read(input logic [11:0] a);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      ra = rdat_a; rb = rdat_b; rc = rdat_c; ea = err_a; rcyc = cyc;
   endtask

   function automatic bit exp_mapped(input int off);
      int w = off / 4;
      return (off % 4 == 0) && (w <= 'h1D || (w >= 'h20 && w <= 'h27) ||
                                (w >= 'h30 && w <= 'h34));
   endfunction

   function automatic logic [31:0] exp_read(input int off);
      case (off)
         'h00: return ID_A;
         'h08: return m_led;
         'h20: return {16'h0, m_lock};
         'h28: return m_cfg0;
         'h2C: return m_cfg1;
         'h30: return m_flags;
         'h38: return m_nv;
         'h40: return m_level;
         'h44: return 32'd1;
         'h84: return PID;
         'h88: return 32'hFF00_0000;
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_led = 0; m_lock = 0; m_cfg0 = 0; m_cfg1 = 0; m_flags = 0; m_level = 0;
   endtask

   task automatic lock_write(input logic [31:0] v);
      bus_write(12'h020, v);
      m_lock = (v == 32'h0000_A05F) ? 16'hA05F : {1'b0, v[14:0]};
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin : main
      logic [31:0] pats [6];
      pats[0] = 32'h0000_F0F0; pats[1] = 32'h0000_000F; pats[2] = 32'hFFFF_0000;
      pats[3] = 32'h1234_5678; pats[4] = 32'h8000_0001; pats[5] = 32'hFFFF_FFFF;
      m_nv = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_led = 0; m_lock = 0; m_cfg0 = 0; m_cfg1 = 0; m_flags = 0; m_level = 0;

      // R1: reset state
      check("R1 led_o", led_a, 32'h0);
      foreach (pats[i]) begin end
      bus_read(12'h008); check("R1 led", ra, 0);
      bus_read(12'h020); check("R1 lock", ra, 0);
      bus_read(12'h028); check("R1 cfg0", ra, 0);
      bus_read(12'h02C); check("R1 cfg1", ra, 0);
      bus_read(12'h030); check("R1 flags", ra, 0);
      bus_read(12'h040); check("R1 rstctl", ra, 0);
      bus_write(12'h03C, 32'hFFFF_FFFF);  // define non-volatile flags

      // R8: constant words on every copy
      bus_read(12'h000); check("R8 id A", ra, ID_A); check("R8 id B", rb, ID_B); check("R8 id C", rc, ID_C);
      bus_read(12'h044); check("R8 one", ra, 1);
      bus_read(12'h084); check("R8 proc0", ra, PID);
      bus_read(12'h088); check("R8 proc1", ra, 32'hFF00_0000);

      // R10: sweep of the lowest 256 byte offsets
      for (int off = 0; off < 256; off++) begin
         if (off == 'h5C) continue;
         bus_read(12'(off));
         check($sformatf("R10 err @%0h", off), 32'(ea), 32'(!exp_mapped(off)));
         check($sformatf("R10 data @%0h", off), ra, exp_mapped(off) ? exp_read(off) : 32'h0);
      end
      bus_read(12'hFFC); check("R10 err high", 32'(ea), 1);
      bus_write(12'h078, 32'h5); check("R10 write err", 32'(ea), 1);
      bus_write(12'h048, 32'h5); check("R10 mapped write no err", 32'(ea), 0);

      // R11: read-back of plain words and LED pins
      for (int b = 0; b < 32; b++) begin
         bus_write(12'h008, 32'h1 << b); m_led = 32'h1 << b;
         check("R11 led_o", led_a, m_led);
         bus_read(12'h008); check("R11 led read", ra, m_led);
      end
      foreach (pats[i]) begin
         bus_write(12'h028, pats[i]); bus_write(12'h02C, ~pats[i]);
         bus_read(12'h028); check("R11 cfg0", ra, pats[i]);
         bus_read(12'h02C); check("R11 cfg1", ra, ~pats[i]);
      end
      m_cfg0 = pats[5]; m_cfg1 = ~pats[5];

      // R2: lock word encoding
      foreach (pats[i]) begin
         lock_write(pats[i]);
         bus_read(12'h020); check("R2 lock", ra, {16'h0, m_lock});
      end
      lock_write(32'h0001_A05F); bus_read(12'h020); check("R2 near key", ra, 32'h205F);
      lock_write(32'h0000_A05F); bus_read(12'h020); check("R2 key", ra, 32'hA05F);

      // R3/R5: locked writes ignored everywhere
      lock_write(32'h0000_1234);
      bus_write(12'h040, 32'hFFFF_FFFF);
      check("R3 no pulse A", 32'(req_a), 0); check("R3 no pulse B", 32'(req_b), 0);
      bus_read(12'h040);
      check("R3 locked A", ra, 0); check("R3 locked B", rb, 0); check("R5 rsv", rc, 0);

      // R4: unlocked; request bits per variant
      lock_write(32'h0000_A05F);
      bus_write(12'h040, 32'h0000_0104); m_level = 32'h104;
      check("R4 pulse bit2", 32'(req_a), 1); check("R4 pulse bit8", 32'(req_b), 1);
      check("R5 no pulse", 32'(req_c), 0);
      @(negedge clk);
      check("R4 single A", 32'(req_a), 0); check("R4 single B", 32'(req_b), 0);
      bus_read(12'h040);
      check("R3 level A", ra, 32'h104); check("R3 level B", rb, 32'h104); check("R5 rsv read", rc, 0);
      bus_write(12'h040, 32'h0000_0004); m_level = 32'h4;
      check("R4 bit2 only A", 32'(req_a), 1); check("R4 bit2 only B", 32'(req_b), 0);
      bus_write(12'h040, 32'h0000_0100); m_level = 32'h100;
      check("R4 bit8 only A", 32'(req_a), 0); check("R4 bit8 only B", 32'(req_b), 1);
      bus_write(12'h040, 32'h0000_0000); m_level = 0;
      check("R4 none A", 32'(req_a), 0); check("R4 none B", 32'(req_b), 0);
      lock_write(32'h0000_0000);
      bus_write(12'h040, 32'h0000_0055);
      bus_read(12'h040); check("R3 relocked", ra, 0); check("R3 relocked B", rb, 0);

      // R6/R7: set and clear semantics
      foreach (pats[i]) begin
         bus_write(12'h030, pats[i]);        m_flags |= pats[i];
         bus_write(12'h034, pats[(i+2)%6]);  m_flags &= ~pats[(i+2)%6];
         bus_read(12'h030); check("R6 flags", ra, m_flags);
         bus_write(12'h038, pats[(i+1)%6]);  m_nv |= pats[(i+1)%6];
         bus_write(12'h03C, pats[(i+3)%6]);  m_nv &= ~pats[(i+3)%6];
         bus_read(12'h038); check("R7 nvflags", ra, m_nv);
      end
      bus_write(12'h030, 32'hA5A5_0F0F); m_flags |= 32'hA5A5_0F0F;
      bus_write(12'h038, 32'h0F00_00F0); m_nv |= 32'h0F00_00F0;
      bus_read(12'h034); check("R6 clear addr reads 0", ra, 0);
      bus_read(12'h03C); check("R7 clear addr reads 0", ra, 0);

      // R7/R1: reset keeps non-volatile flags only
      do_reset();
      bus_read(12'h038); check("R7 nv kept", ra, m_nv);
      bus_read(12'h030); check("R1 flags cleared", ra, 0);
      bus_read(12'h028); check("R1 cfg cleared", ra, 0);
      check("R1 led_o cleared", led_a, 0);

      // R9: tick growth over several spans
      for (int k = 0; k < 6; k++) begin
         logic [31:0] t0;
         int c0, d, lo, hi, dl;
         bus_read(12'h05C); t0 = ra; c0 = rcyc;
         repeat (k * 37 + 3) @(negedge clk);
         bus_read(12'h05C);
         d  = rcyc - c0;
         lo = (d * 24) / 50;
         hi = (d * 24 + 49) / 50;
         dl = int'(ra - t0);
         check("R9 tick delta", 32'(dl), (dl >= lo && dl <= hi) ? 32'(dl) : 32'(lo));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule